// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Register Bank

This block holds the configuration space of a DRAM controller as a bank of 32-bit words on a simple word-addressed read/write bus. A key register guards most of the words. After reset the bank is soft-locked. Software opens it by writing a magic key, closes it again with any other value, or seals it until the next reset with a second magic key. A fixed list of words stays writable in every lock state.

The configuration word keeps its read-only fields whatever is written to it. These fields are the hardware version, the VGA aperture, the reserved bits and the RAM-size code, which comes from a build parameter. Two status-like words are rewritten on each write so that they always report success. A PHY window of words resets to "calibration passed" values. Accesses outside the implemented words read as zero and are otherwise ignored.

A dropped write raises a one-cycle `write_blocked` pulse. Reads take one cycle and change no state.

Top module: `dramcfg_regbank`

## Requirements
- R1: After reset these words read as follows: key word (word 0x000) is 0x00, configuration word (word 0x001) is 0x3000000C with the size code in bits 1:0, word 0x100 is 0x00000002, words 0x11A and 0x11F are 0x000000FF, word 0x114 is 0x0FFFFFFF. Every other implemented word reads 0.
- R2: Writing 0xFC600309 to the key word makes it read 0x01. Protected words then take writes.
- R3: Writing a value other than the two keys to the key word makes it read 0x00. While it reads 0x00, a write to any protected word other than the key word leaves that word unchanged.
- R4: Writing 0xDEADDEAD to the key word makes it read 0x10. From then until reset, every write to a protected word is dropped, the key word included.
- R5: Words 0x014, 0x01B, 0x01D, 0x01E, 0x01F, 0x022, 0x023 and 0x02D store any written value in every lock state.
- R6: A write to the configuration word stores the data with bits 31:28 forced to 3, bit 19, bits 18:14 and bit 6 forced to 0, bits 3:2 forced to 2'b11, and bits 1:0 forced to the size code.
- R7: The size code is 0, 1, 2 or 3 for a RAM_MIB of 256, 512, 1024 or 2048.
- R8: A write to word 0x018 stores the data with bit 0 cleared and bit 4 set.
- R9: A write to word 0x01C stores the data with bit 12 set and bit 13 cleared.
- R10: The implemented words are 0x000 to 0x02F and 0x100 to 0x11F. Any other address reads 0, drops writes and never raises `write_blocked`.
- R11: `write_blocked` is high for exactly the one cycle after a write that a soft lock or a hard lock dropped, and is low otherwise.
- R12: `rdata` and `rd_valid` present a read one cycle after `rd_en`, and reads change no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 10 | Word address (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after a read request |
| write_blocked | output | 1 | One-cycle pulse after a write dropped by the lock |

## Verification
Several checks run on every cycle. The hard lock is checked to persist. Every soft-locked write to a protected word must be followed by a blocked pulse. An out-of-range write must never cause one, and a blocked pulse must only follow a write. Any read of the configuration word must return its fixed fields. Only the bench scenarios can show the rest: the stored values after each rewrite rule, the exempt words taking data under a hard lock, and reset being the only way out of the hard lock.

// File: rtl/dramcfg_pkg.sv
package dramcfg_pkg;

  localparam int DW        = 32;
  localparam int AW        = 10;
  localparam int LO_DEPTH  = 48;
  localparam int PHY_BASE  = 256;
  localparam int PHY_DEPTH = 32;

  localparam logic [AW-1:0] A_KEY  = 10'h000;
  localparam logic [AW-1:0] A_CONF = 10'h001;
  localparam logic [AW-1:0] A_STAT = 10'h018;
  localparam logic [AW-1:0] A_TEST = 10'h01C;

  localparam logic [DW-1:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [DW-1:0] KEY_SEAL = 32'hDEAD_DEAD;

  localparam logic [DW-1:0] CONF_RO_MASK = 32'hF00F_C04F;
  localparam logic [DW-1:0] CONF_BASE    = 32'h3000_000C;

  typedef enum logic [7:0] {
    LK_SOFT = 8'h00,
    LK_OPEN = 8'h01,
    LK_HARD = 8'h10
  } lock_e;

  function automatic logic [1:0] size_code(input int mib);
    case (mib)
      512:     return 2'd1;
      1024:    return 2'd2;
      2048:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic always_open(input logic [AW-1:0] a);
    case (a)
      10'h014, 10'h01B, 10'h01D, 10'h01E,
      10'h01F, 10'h022, 10'h023, 10'h02D: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] conf_fixed(input logic [1:0] code);
    return CONF_BASE | {30'b0, code};
  endfunction

  function automatic logic [DW-1:0] shape_write(input logic [AW-1:0] a,
                                                input logic [DW-1:0] d,
                                                input logic [1:0]    code);
    logic [DW-1:0] r;
    r = d;
    case (a)
      A_CONF: r = (d & ~CONF_RO_MASK) | conf_fixed(code);
      A_STAT: r = (d & ~32'h0000_0001) | 32'h0000_0010;
      A_TEST: r = (d & ~32'h0000_2000) | 32'h0000_1000;
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] reset_word(input logic [AW-1:0] a,
                                               input logic [1:0]    code);
    case (a)
      A_CONF:  return conf_fixed(code);
      10'h100: return 32'h0000_0002;
      10'h11A: return 32'h0000_00FF;
      10'h11F: return 32'h0000_00FF;
      10'h114: return 32'h0FFF_FFFF;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/dramcfg_keylock.sv
module dramcfg_keylock
  import dramcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [DW-1:0] key_data,
  output lock_e         lock_state
);

  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we) begin
      if (key_data == KEY_OPEN)      state_d = LK_OPEN;
      else if (key_data == KEY_SEAL) state_d = LK_HARD;
      else                           state_d = LK_SOFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_SOFT;
    else        state_q <= state_d;
  end

  assign lock_state = state_q;

  // R4
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_HARD) |=> (state_q == LK_HARD));

endmodule

// File: rtl/dramcfg_wordstore.sv
module dramcfg_wordstore
  import dramcfg_pkg::*;
#(
  parameter int         BASE      = 0,
  parameter int         DEPTH     = 48,
  parameter logic [1:0] SIZE_CODE = 2'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] rword
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] words [DEPTH];
  logic [AW-1:0] rel;
  logic [IW-1:0] idx;

  assign rel = addr - AW'(BASE);
  assign hit = (rel < AW'(DEPTH));
  assign idx = IW'(rel);

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [AW-1:0] MY_ADDR = AW'(BASE + i);
    logic [DW-1:0] q, d;
    logic          en;

    assign en = we && (addr == MY_ADDR);

    always_comb begin
      d = q;
      if (en) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reset_word(MY_ADDR, SIZE_CODE);
      else        q <= d;
    end

    assign words[i] = q;
  end

  assign rword = hit ? words[idx] : '0;

endmodule

// File: rtl/dramcfg_regbank.sv
module dramcfg_regbank
  import dramcfg_pkg::*;
#(
  parameter int RAM_MIB = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [9:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rd_valid,
  output logic        write_blocked
);

  localparam logic [1:0] SZ = size_code(RAM_MIB);

  lock_e         lock;
  logic          lo_hit, phy_hit, in_range, exempt, is_key;
  logic          accept, drop, key_we;
  logic [DW-1:0] store_data, lo_word, phy_word, rd_word;

  assign exempt   = always_open(addr);
  assign is_key   = (addr == A_KEY);
  assign in_range = lo_hit || phy_hit;

  // Write gating: exempt first, then hard lock, then key, then soft lock
  always_comb begin
    accept = 1'b0;
    drop   = 1'b0;
    key_we = 1'b0;
    if (wr_en && in_range) begin
      if (exempt)               accept = 1'b1;
      else if (lock == LK_HARD) drop   = 1'b1;
      else if (is_key)          key_we = 1'b1;
      else if (lock == LK_SOFT) drop   = 1'b1;
      else                      accept = 1'b1;
    end
  end

  assign store_data = shape_write(addr, wdata, SZ);

  dramcfg_keylock u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_we     (key_we),
    .key_data   (wdata),
    .lock_state (lock)
  );

  dramcfg_wordstore #(.BASE(0), .DEPTH(LO_DEPTH), .SIZE_CODE(SZ)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept && lo_hit),
    .addr  (addr),
    .wdata (store_data),
    .hit   (lo_hit),
    .rword (lo_word)
  );

  dramcfg_wordstore #(.BASE(PHY_BASE), .DEPTH(PHY_DEPTH), .SIZE_CODE(SZ)) u_phy (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept && phy_hit),
    .addr  (addr),
    .wdata (store_data),
    .hit   (phy_hit),
    .rword (phy_word)
  );

  assign rd_word = is_key ? {24'b0, lock} : (lo_word | phy_word);

  logic [DW-1:0] rdata_q, rdata_d;
  logic          rvld_q, rvld_d, blk_q, blk_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_word;
    rvld_d = rd_en;
    blk_d  = drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      rvld_q  <= rvld_d;
      blk_q   <= blk_d;
    end
  end

  assign rdata         = rdata_q;
  assign rd_valid      = rvld_q;
  assign write_blocked = blk_q;

  // R11
  blk_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> $past(wr_en));

  // R3
  soft_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_range && !exempt && !is_key && lock == LK_SOFT) |=> write_blocked);

  // R10
  oor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> !write_blocked);

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R6
  conf_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CONF) |=> ((rdata & CONF_RO_MASK) == conf_fixed(SZ)));

endmodule

// File: tb/tb_dramcfg_regbank.sv
module tb_dramcfg_regbank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [9:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rd_valid, write_blocked;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dramcfg_regbank #(.RAM_MIB(1024)) dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata),
    .rd_valid (rd_valid), .write_blocked (write_blocked)
  );

  localparam logic [31:0] CONF_RST = 32'h3000_000E;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, output logic blk);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    blk = write_blocked;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    check("R12 rd_valid", {31'b0, rd_valid}, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(10'h000, v); check("R1 key", v, 32'h0);
    rd(10'h001, v); check("R1 R7 conf", v, CONF_RST);
    rd(10'h100, v); check("R1 phy100", v, 32'h2);
    rd(10'h11A, v); check("R1 phy11A", v, 32'hFF);
    rd(10'h11F, v); check("R1 phy11F", v, 32'hFF);
    rd(10'h114, v); check("R1 phy114", v, 32'h0FFF_FFFF);
    rd(10'h018, v); check("R1 stat", v, 32'h0);
    rd(10'h101, v); check("R1 phy101", v, 32'h0);
  endtask

  task automatic t_soft();
    logic b; logic [31:0] v;
    wr(10'h001, 32'h0, b);       check("R11 conf drop pulse", {31'b0, b}, 32'h1);
    @(negedge clk);              check("R11 one cycle", {31'b0, write_blocked}, 32'h0);
    rd(10'h001, v);              check("R3 conf kept", v, CONF_RST);
    wr(10'h101, 32'h1234, b);    check("R3 phy drop", {31'b0, b}, 32'h1);
    rd(10'h101, v);              check("R3 phy kept", v, 32'h0);
    wr(10'h000, 32'h1234_5678, b); check("R3 key write accepted", {31'b0, b}, 32'h0);
    rd(10'h000, v);              check("R3 key soft", v, 32'h0);
  endtask

  task automatic t_open();
    logic b; logic [31:0] v;
    wr(10'h000, 32'hFC60_0309, b); rd(10'h000, v); check("R2 key open", v, 32'h1);
    wr(10'h101, 32'h0000_A5A5, b); check("R2 no pulse", {31'b0, b}, 32'h0);
    rd(10'h101, v);                check("R2 phy write", v, 32'h0000_A5A5);
  endtask

  task automatic t_conf();
    logic b; logic [31:0] v;
    wr(10'h001, 32'hFFFF_FFFF, b); rd(10'h001, v); check("R6 conf ones", v, 32'h3FF0_3FBE);
    wr(10'h001, 32'h0, b);         rd(10'h001, v); check("R6 R7 conf zero", v, CONF_RST);
  endtask

  task automatic t_rewrite();
    logic b; logic [31:0] v;
    wr(10'h018, 32'hFFFF_FFFF, b); rd(10'h018, v); check("R8 stat ones", v, 32'hFFFF_FFFE);
    wr(10'h018, 32'h1, b);         rd(10'h018, v); check("R8 stat busy", v, 32'h10);
    wr(10'h01C, 32'hFFFF_FFFF, b); rd(10'h01C, v); check("R9 test ones", v, 32'hFFFF_DFFF);
    wr(10'h01C, 32'h0, b);         rd(10'h01C, v); check("R9 test zero", v, 32'h1000);
  endtask

  task automatic t_exempt(input string tag);
    logic b; logic [31:0] v;
    logic [9:0] lst [8] = '{10'h014, 10'h01B, 10'h01D, 10'h01E,
                            10'h01F, 10'h022, 10'h023, 10'h02D};
    for (int i = 0; i < 8; i++) begin
      wr(lst[i], 32'hC0DE_0000 | 32'(lst[i]), b);
      check({tag, " exempt no pulse"}, {31'b0, b}, 32'h0);
      rd(lst[i], v);
      check({tag, " exempt data"}, v, 32'hC0DE_0000 | 32'(lst[i]));
    end
  endtask

  task automatic t_oor();
    logic b; logic [31:0] v;
    wr(10'h030, 32'hFFFF_FFFF, b); check("R10 no pulse 030", {31'b0, b}, 32'h0);
    rd(10'h030, v);                check("R10 read 030", v, 32'h0);
    wr(10'h120, 32'hFFFF_FFFF, b); check("R10 no pulse 120", {31'b0, b}, 32'h0);
    rd(10'h120, v);                check("R10 read 120", v, 32'h0);
    rd(10'h3FF, v);                check("R10 read 3FF", v, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    rd(10'h101, v); rd(10'h101, v); check("R12 reread same", v, 32'h0000_A5A5);
    @(negedge clk); check("R12 valid drops", {31'b0, rd_valid}, 32'h0);
  endtask

  task automatic t_hard();
    logic b; logic [31:0] v;
    wr(10'h000, 32'hFC60_0309, b);
    wr(10'h000, 32'hDEAD_DEAD, b); rd(10'h000, v); check("R4 sealed", v, 32'h10);
    wr(10'h000, 32'hFC60_0309, b); check("R4 R11 key pulse", {31'b0, b}, 32'h1);
    rd(10'h000, v);                check("R4 stays sealed", v, 32'h10);
    wr(10'h101, 32'h5555, b);      check("R4 phy pulse", {31'b0, b}, 32'h1);
    rd(10'h101, v);                check("R4 phy kept", v, 32'h0000_A5A5);
    t_exempt("R5 hard");
    apply_reset();
    rd(10'h000, v);                check("R4 reset clears", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    apply_reset();
    t_reset();
    t_soft();
    t_exempt("R5 soft");
    t_oor();
    t_open();
    t_conf();
    t_rewrite();
    t_readonly();
    t_hard();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule